// File: doc/BRIEF.md
# Split Dual-Rail Serializer Transmitter

This block takes one parallel word at a time from a sender and sends it as a serial stream of two-phase level-encoded dual-rail symbols on two wires: a phase rail and a state rail. Each symbol costs exactly one wire transition. Every word goes out as a start symbol of value 1 followed by its data bits, least significant first. The block is a synchronous model clocked at the bit rate. It does not model the channel driver or any gate-level asynchronous timing.

Inside, an accepted word is split into two half-rate shift registers. One holds the symbols at even sequence positions: the start bit and data bits 1, 3, 5 and so on. The other holds the symbols at odd positions: data bits 0, 2, 4 and so on. A merge stage takes the next symbol from the two registers in turn. The encoder turns each symbol into rail levels as it is shifted out.

The sender raises a request with a word and holds both until it sees the one-cycle acknowledge. There is one acknowledge per word. A controller with three states drives the block:
- IDLE waits for a request.
- START sends the start symbol.
- DATA sends the data bits.

The transitions are:
- IDLE to START when a request is accepted.
- START to DATA always.
- DATA to IDLE after the last data bit.

The word width `W` is a parameter. It must be even and at least 2. Its default is 16.

Top module: `ledr_split_tx`

## Requirements
- R1: While reset is held and after it is released, with no request pending, `rail_p`, `rail_s`, `busy` and `ld_ack` are all 0.
- R2: `ld_ack` is 1 only in a cycle where `ld_req` is 1 and `busy` is 0. Each acknowledged request is followed, in the next cycle, by `busy` rising, so each word is acknowledged exactly once.
- R3: On every clock edge that follows a cycle with `busy` high, exactly one of `rail_p` and `rail_s` toggles. On every edge that follows a cycle with `busy` low, neither rail changes.
- R4: The first symbol of every word, symbol index 0, carries the value 1.
- R5: The value carried by symbol index k is recovered as `rail_p` when k is odd and as the inverse of `rail_p` when k is even.
- R6: The XOR of `rail_p` and `rail_s` flips on every symbol. This alternation continues across word boundaries, starting from 0 after reset.
- R7: Symbol k, for k from 1 to W, carries data bit k-1 of the accepted word. Symbol k is visible on the rails after the (k+1)-th rising edge following the accepting edge. `busy` is high for exactly W+1 cycles per word.
- R8: A request that arrives or is held while a word is being sent is not acknowledged until `busy` is 0. It is then accepted, with at least one cycle of `busy` low between two words.
- R9: Changes to `ld_data` after the accepting edge have no effect on the symbols of the word being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_req | input | 1 | Sender has a word ready |
| ld_data | input | W | Word to send, held with `ld_req` |
| ld_ack | output | 1 | Word accepted on this clock edge (one per word) |
| busy | output | 1 | A word is being serialized |
| rail_p | output | 1 | Phase rail of the dual-rail stream |
| rail_s | output | 1 | State rail of the dual-rail stream |

## Verification
Two functions can fall in the same cycle: the last data symbol leaving the odd/even merge, and a new request that is held and waiting to be accepted. To provoke this, the bench keeps `ld_req` high with the next word all through a transfer. It then checks that `ld_ack` stays low while `busy` is high and rises in the first cycle `busy` is low. The next word must then start with a transition on the correct rail, so that the phase alternation carries on unbroken across the join. A change to `ld_data` in the middle of the transfer also checks that the symbols in flight come from the registers loaded at acceptance and not from the live input.

// File: rtl/ledr_pkg.sv
package ledr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2
    } tx_state_e;

endpackage

// File: rtl/ledr_half_sreg.sv
// Half-rate shift register: parallel load, shifts toward bit 0 on enable.
module ledr_half_sreg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] load_val,
    input  logic         shift,
    output logic         head
);

    logic [N-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= q >> 1;
        end
    end

    assign head = q[0];

endmodule

// File: rtl/ledr_encoder.sv
// Combinational dual-rail encoder for one symbol.
module ledr_encoder (
    input  logic sym,
    input  logic odd_pos,
    input  logic phase_q,
    output logic p_next,
    output logic s_next,
    output logic phase_next
);

    always_comb begin
        phase_next = ~phase_q;
        p_next     = odd_pos ? sym : ~sym;
        s_next     = p_next ^ phase_next;
    end

endmodule

// File: rtl/ledr_split_tx.sv
module ledr_split_tx
    import ledr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_req,
    input  logic [W-1:0] ld_data,
    output logic         ld_ack,
    output logic         busy,
    output logic         rail_p,
    output logic         rail_s
);

    localparam int HALF = W / 2;
    localparam int EVN  = HALF + 1;
    localparam int ODN  = HALF;
    localparam int IW   = $clog2(W + 1);

    tx_state_e      state_q, state_d;
    logic [IW-1:0]  idx_q;
    logic           p_q, s_q, ph_q;
    logic [EVN-1:0] even_init;
    logic [ODN-1:0] odd_init;
    logic           even_head, odd_head;
    logic           sending, last_sym, cur_sym;
    logic           p_n, s_n, ph_n;

    // Split: even positions hold start + odd data bits, odd positions hold even data bits.
    assign even_init[0] = 1'b1;
    for (genvar m = 1; m < EVN; m++) begin : g_even
        assign even_init[m] = ld_data[2*m-1];
    end
    for (genvar m = 0; m < ODN; m++) begin : g_odd
        assign odd_init[m] = ld_data[2*m];
    end

    assign sending  = (state_q != ST_IDLE);
    assign last_sym = (idx_q == IW'(W));
    assign ld_ack   = (state_q == ST_IDLE) && ld_req;
    assign busy     = sending;

    ledr_half_sreg #(.N(EVN)) u_even (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_ack),
        .load_val (even_init),
        .shift    (sending && !idx_q[0]),
        .head     (even_head)
    );

    ledr_half_sreg #(.N(ODN)) u_odd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_ack),
        .load_val (odd_init),
        .shift    (sending && idx_q[0]),
        .head     (odd_head)
    );

    // Merge stage alternates between the two half-rate registers.
    assign cur_sym = idx_q[0] ? odd_head : even_head;

    ledr_encoder u_enc (
        .sym        (cur_sym),
        .odd_pos    (idx_q[0]),
        .phase_q    (ph_q),
        .p_next     (p_n),
        .s_next     (s_n),
        .phase_next (ph_n)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (ld_req)   state_d = ST_START;
            ST_START:               state_d = ST_DATA;
            ST_DATA:  if (last_sym) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            p_q   <= 1'b0;
            s_q   <= 1'b0;
            ph_q  <= 1'b0;
        end else if (ld_ack) begin
            idx_q <= '0;
        end else if (sending) begin
            idx_q <= idx_q + 1'b1;
            p_q   <= p_n;
            s_q   <= s_n;
            ph_q  <= ph_n;
        end
    end

    assign rail_p = p_q;
    assign rail_s = s_q;

endmodule

// File: rtl/ledr_split_tx_chk.sv
module ledr_split_tx_chk #(
    parameter int W = 16
) (
    input logic clk,
    input logic rst_n,
    input logic ld_req,
    input logic ld_ack,
    input logic busy,
    input logic rail_p,
    input logic rail_s
);

    localparam int CW = $clog2(W + 2);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    a_r2_ack_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ack |-> (ld_req && !busy));

    a_r2_ack_starts_word: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ack |=> busy);

    a_r3_one_rail_moves: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($countones({rail_p ^ $past(rail_p), rail_s ^ $past(rail_s)}) == 1));

    a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(rail_p) && $stable(rail_s)));

    a_r6_parity_flips: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((rail_p ^ rail_s) != $past(rail_p ^ rail_s)));

    a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (run_q < CW'(W))) |=> busy);

    a_r7_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (run_q == CW'(W))) |=> !busy);

endmodule

bind ledr_split_tx ledr_split_tx_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_req (ld_req),
    .ld_ack (ld_ack),
    .busy   (busy),
    .rail_p (rail_p),
    .rail_s (rail_s)
);

// File: tb/ledr_split_tx_tb.sv
module ledr_split_tx_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld_req = 1'b0;
    logic [W-1:0] ld_data = '0;
    logic         ld_ack, busy, rail_p, rail_s;

    int n_vec = 0;
    int n_bad = 0;
    bit prev_p = 1'b0;
    bit prev_s = 1'b0;
    bit ph     = 1'b0;

    always #4 clk = ~clk;

    ledr_split_tx #(.W(W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_req  (ld_req),
        .ld_data (ld_data),
        .ld_ack  (ld_ack),
        .busy    (busy),
        .rail_p  (rail_p),
        .rail_s  (rail_s)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Sends one word; optionally keeps the request high with the next word (R8)
    // or scrambles ld_data mid-transfer (R9).
    task automatic xmit(input logic [W-1:0] w, input bit keep_req, input logic [W-1:0] nxt);
        ld_data = w;
        ld_req  = 1'b1;
        #1;
        while (!ld_ack) begin
            @(posedge clk); #1;
        end
        check(busy == 1'b0, "R2 ack only when idle", busy, 0);
        @(posedge clk); #1;
        check(busy == 1'b1, "R2 busy after ack", busy, 1);
        if (keep_req) ld_data = nxt;
        else begin
            ld_req  = 1'b0;
            ld_data = ~w;
        end
        for (int k = 0; k <= W; k++) begin
            bit exp_b;
            bit got_b;
            @(posedge clk); #1;
            exp_b = (k == 0) ? 1'b1 : w[k-1];
            got_b = (k % 2 == 1) ? rail_p : ~rail_p;
            ph = ~ph;
            check(((rail_p ^ prev_p) + (rail_s ^ prev_s)) == 1, "R3 one rail per symbol",
                  (rail_p ^ prev_p) + (rail_s ^ prev_s), 1);
            check((rail_p ^ rail_s) == ph, "R6 parity alternates", rail_p ^ rail_s, ph);
            if (k == 0) check(got_b == 1'b1, "R4 start symbol", got_b, 1);
            else        check(got_b == exp_b, "R5/R7/R9 data symbol", got_b, exp_b);
            if (k < W) begin
                check(busy == 1'b1, "R7 busy during word", busy, 1);
                check(ld_ack == 1'b0, "R8 no ack while busy", ld_ack, 0);
            end else begin
                check(busy == 1'b0, "R7 busy ends after W+1", busy, 0);
                check(ld_ack == keep_req, "R8 held request acked when idle", ld_ack, keep_req);
            end
            prev_p = rail_p;
            prev_s = rail_s;
        end
    endtask

    task automatic t_reset();
        #1;
        check(rail_p == 0 && rail_s == 0, "R1 rails in reset", {rail_p, rail_s}, 0);
        check(busy == 0 && ld_ack == 0, "R1 busy/ack in reset", {busy, ld_ack}, 0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        check(rail_p == 0 && rail_s == 0, "R1 rails after reset", {rail_p, rail_s}, 0);
        check(busy == 0 && ld_ack == 0, "R1 busy/ack after reset", {busy, ld_ack}, 0);
    endtask

    task automatic t_idle_quiet();
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); #1;
            check(rail_p == prev_p && rail_s == prev_s, "R3 idle rails hold",
                  {rail_p, rail_s}, {prev_p, prev_s});
            check(busy == 0, "R7 idle busy low", busy, 0);
        end
    endtask

    task automatic t_singles();
        xmit(16'h0000, 1'b0, '0);
        t_idle_quiet();
        xmit(16'hFFFF, 1'b0, '0);
        xmit(16'hA5A5, 1'b0, '0);
        xmit(16'h8001, 1'b0, '0);
    endtask

    task automatic t_back_to_back();
        xmit(16'h5555, 1'b1, 16'h3C96);
        xmit(16'h3C96, 1'b1, 16'hF00F);
        xmit(16'hF00F, 1'b0, '0);
        t_idle_quiet();
    endtask

    initial begin
        t_reset();
        t_singles();
        t_back_to_back();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule